// File: doc/BRIEF.md
# Chip-Select-Gated Configurable Register Buffer

This block re-times the address and command bits that a memory controller sends to a group of DRAM devices. All state changes on the rising edge of a single clock. Two static mode inputs choose how the inputs map to the outputs. In wide mode, 22 data lanes plus the on-die-termination (ODT), clock-enable (CKE) and chip-select bits are registered one to one, which gives 25 bits in total. In split mode, 11 data bits plus the same three control bits are registered once and driven onto two identical output copies, A and B. Split mode has two input-to-bit assignments.

Two active-low selects control the data outputs. The device select `dcs_n` and the register select `csr_n` together decide whether the data outputs load new values or hold. The ODT, CKE and chip-select outputs update on every edge. An asynchronous active-low reset clears every register and forces every output low at once. The block has no back-pressure: it accepts a new word on every clock edge, and nothing at its edge stalls or acknowledges. It is a fixed-latency pipeline stage of one cycle.

Top module: `cs_gated_regbuf`

## Requirements
- R1: With `mode_split`=0, a clock edge at which `dcs_n` or `csr_n` is low sets `qa` to `din`, `odt_qa` to `odt_in`, `cke_qa` to `cke_in` and `cs_qa_n` to `dcs_n`.
- R2: With `mode_split`=1 and `map_b`=0, registered bit k (k=0..10) is taken from `din[k]`, and ODT and CKE come from `odt_in` and `cke_in`. Each registered bit appears on both copies: `qa[k]` and `qb[k]`, `odt_qa`/`odt_qb`, `cke_qa`/`cke_qb`, `cs_qa_n`/`cs_qb_n`.
- R3: With `mode_split`=1 and `map_b`=1, ODT is taken from `din[9]` and CKE from `din[10]`. Registered bits 0..8 come from `din[0..8]`, bit 9 from `din[11]` and bit 10 from `din[12]`. `odt_in` and `cke_in` have no effect.
- R4: A clock edge at which both `dcs_n` and `csr_n` are high leaves the data outputs (`qa`, `qb`) unchanged, provided the mode inputs are unchanged.
- R5: Either select low alone is enough to load new data: `dcs_n`=0 with `csr_n`=1 loads, and `dcs_n`=1 with `csr_n`=0 loads.
- R6: The ODT, CKE and chip-select outputs take their new inputs on every clock edge, whatever the state of the selects.
- R7: While `rst_n` is low, every output is 0 at once, without waiting for a clock edge, and all registers are cleared.
- R8: After `rst_n` rises, with all inputs low and the clock running, every output stays 0.
- R9: Outputs unused in the current mode are driven 0: `qa[21:11]` in split mode, and `qb`, `odt_qb`, `cke_qb`, `cs_qb_n` in wide mode.
- R10: A change of the mode inputs takes effect at the next clock edge and does not alter the held data register. If wide mode held `qa`=V and then switches to split while both selects are high, the outputs show `qa`={0, V[10:0]} and `qb`=V[10:0] after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_split | input | 1 | 0: wide one-to-one, 1: split one-to-two |
| map_b | input | 1 | Split-mode assignment: 0 first, 1 second |
| din | input | 22 | Data lanes |
| odt_in | input | 1 | Termination control bit (dedicated pin) |
| cke_in | input | 1 | Clock-enable bit (dedicated pin) |
| dcs_n | input | 1 | Device chip select, active low |
| csr_n | input | 1 | Register select, active low |
| qa | output | 22 | Data outputs, copy A (all lanes in wide mode) |
| qb | output | 11 | Data outputs, copy B (split mode only) |
| odt_qa | output | 1 | Registered termination control, copy A |
| odt_qb | output | 1 | Registered termination control, copy B |
| cke_qa | output | 1 | Registered clock enable, copy A |
| cke_qb | output | 1 | Registered clock enable, copy B |
| cs_qa_n | output | 1 | Registered chip select, copy A |
| cs_qb_n | output | 1 | Registered chip select, copy B |

## Verification
The hardest state to reach from the ports is a mode switch during a hold. The data register must keep content captured under the old mapping while the output fan-out already follows the new mode. The stimulus loads a wide word and then, on a single edge, raises both selects and switches to split mode, so the held upper lanes become invisible while the lower lanes appear on both copies. A second hard case is a reset that falls between clock edges while the outputs carry non-zero data. The bench drops `rst_n` a few nanoseconds after an edge and samples the outputs before the next edge, which shows whether the clear acts asynchronously.

// File: rtl/cs_gated_regbuf_pkg.sv
`timescale 1ns/1ps
package cs_gated_regbuf_pkg;
  typedef struct packed {
    logic odt;
    logic cke;
    logic cs_n;
  } ctrl_bits_t;
endpackage

// File: rtl/regbuf_lane_map.sv
`timescale 1ns/1ps
module regbuf_lane_map
  import cs_gated_regbuf_pkg::*;
#(
  parameter int WIDE_W     = 22,
  parameter int SPLIT_W    = 11,
  parameter int B_ODT_LANE = 9,
  parameter int B_CKE_LANE = 10,
  parameter int B_EXTRA0   = 11,
  parameter int B_EXTRA1   = 12
) (
  input  logic              mode_split,
  input  logic              map_b,
  input  logic [WIDE_W-1:0] din,
  input  logic              odt_in,
  input  logic              cke_in,
  input  logic              dcs_n,
  output logic [WIDE_W-1:0] nxt_data,
  output ctrl_bits_t        nxt_ctrl
);
  localparam int UPPER_W = WIDE_W - SPLIT_W;

  logic [SPLIT_W-1:0] split_vec;

  // In the second assignment the lanes that carry ODT and CKE are
  // replaced by two lanes that the first assignment leaves idle.
  for (genvar k = 0; k < SPLIT_W; k++) begin : g_map
    localparam int SRC_B = (k == B_ODT_LANE) ? B_EXTRA0 :
                           ((k == B_CKE_LANE) ? B_EXTRA1 : k);
    assign split_vec[k] = map_b ? din[SRC_B] : din[k];
  end

  logic use_lane_ctrl;
  assign use_lane_ctrl = mode_split & map_b;

  always_comb begin
    nxt_data      = mode_split ? {{UPPER_W{1'b0}}, split_vec} : din;
    nxt_ctrl.odt  = use_lane_ctrl ? din[B_ODT_LANE] : odt_in;
    nxt_ctrl.cke  = use_lane_ctrl ? din[B_CKE_LANE] : cke_in;
    nxt_ctrl.cs_n = dcs_n;
  end
endmodule

// File: rtl/regbuf_hold_bank.sv
`timescale 1ns/1ps
module regbuf_hold_bank #(
  parameter int W = 22
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (load_en) q <= d;
  end
endmodule

// File: rtl/regbuf_ctrl_stage.sv
`timescale 1ns/1ps
module regbuf_ctrl_stage
  import cs_gated_regbuf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  ctrl_bits_t nxt_ctrl,
  input  logic       mode_split,
  output ctrl_bits_t ctrl_r,
  output logic       split_r
);
  // Control bits and the mode copy load on every edge: no select gating.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_r  <= '0;
      split_r <= 1'b0;
    end else begin
      ctrl_r  <= nxt_ctrl;
      split_r <= mode_split;
    end
  end
endmodule

// File: rtl/regbuf_fanout.sv
`timescale 1ns/1ps
module regbuf_fanout
  import cs_gated_regbuf_pkg::*;
#(
  parameter int WIDE_W  = 22,
  parameter int SPLIT_W = 11
) (
  input  logic [WIDE_W-1:0]  data_r,
  input  ctrl_bits_t         ctrl_r,
  input  logic               split_r,
  output logic [WIDE_W-1:0]  qa,
  output logic [SPLIT_W-1:0] qb,
  output logic               odt_qa,
  output logic               odt_qb,
  output logic               cke_qa,
  output logic               cke_qb,
  output logic               cs_qa_n,
  output logic               cs_qb_n
);
  localparam int UPPER_W = WIDE_W - SPLIT_W;

  always_comb begin
    qa      = split_r ? {{UPPER_W{1'b0}}, data_r[SPLIT_W-1:0]} : data_r;
    qb      = split_r ? data_r[SPLIT_W-1:0] : '0;
    odt_qa  = ctrl_r.odt;
    cke_qa  = ctrl_r.cke;
    cs_qa_n = ctrl_r.cs_n;
    odt_qb  = split_r & ctrl_r.odt;
    cke_qb  = split_r & ctrl_r.cke;
    cs_qb_n = split_r & ctrl_r.cs_n;
  end
endmodule

// File: rtl/cs_gated_regbuf.sv
`timescale 1ns/1ps
module cs_gated_regbuf
  import cs_gated_regbuf_pkg::*;
#(
  parameter int WIDE_W     = 22,
  parameter int SPLIT_W    = 11,
  parameter int B_ODT_LANE = 9,
  parameter int B_CKE_LANE = 10,
  parameter int B_EXTRA0   = 11,
  parameter int B_EXTRA1   = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_split,
  input  logic               map_b,
  input  logic [WIDE_W-1:0]  din,
  input  logic               odt_in,
  input  logic               cke_in,
  input  logic               dcs_n,
  input  logic               csr_n,
  output logic [WIDE_W-1:0]  qa,
  output logic [SPLIT_W-1:0] qb,
  output logic               odt_qa,
  output logic               odt_qb,
  output logic               cke_qa,
  output logic               cke_qb,
  output logic               cs_qa_n,
  output logic               cs_qb_n
);
  logic [WIDE_W-1:0] nxt_data;
  logic [WIDE_W-1:0] data_r;
  ctrl_bits_t        nxt_ctrl;
  ctrl_bits_t        ctrl_r;
  logic              split_r;
  logic              load_en;

  // Data loads when at least one select is asserted (low).
  assign load_en = ~(dcs_n & csr_n);

  regbuf_lane_map #(
    .WIDE_W(WIDE_W), .SPLIT_W(SPLIT_W),
    .B_ODT_LANE(B_ODT_LANE), .B_CKE_LANE(B_CKE_LANE),
    .B_EXTRA0(B_EXTRA0), .B_EXTRA1(B_EXTRA1)
  ) map_i (
    .mode_split(mode_split), .map_b(map_b), .din(din),
    .odt_in(odt_in), .cke_in(cke_in), .dcs_n(dcs_n),
    .nxt_data(nxt_data), .nxt_ctrl(nxt_ctrl)
  );

  regbuf_hold_bank #(.W(WIDE_W)) bank_i (
    .clk(clk), .rst_n(rst_n), .load_en(load_en),
    .d(nxt_data), .q(data_r)
  );

  regbuf_ctrl_stage ctrl_i (
    .clk(clk), .rst_n(rst_n), .nxt_ctrl(nxt_ctrl),
    .mode_split(mode_split), .ctrl_r(ctrl_r), .split_r(split_r)
  );

  regbuf_fanout #(.WIDE_W(WIDE_W), .SPLIT_W(SPLIT_W)) fan_i (
    .data_r(data_r), .ctrl_r(ctrl_r), .split_r(split_r),
    .qa(qa), .qb(qb), .odt_qa(odt_qa), .odt_qb(odt_qb),
    .cke_qa(cke_qa), .cke_qb(cke_qb),
    .cs_qa_n(cs_qa_n), .cs_qb_n(cs_qb_n)
  );
endmodule

// File: rtl/cs_gated_regbuf_chk.sv
`timescale 1ns/1ps
module cs_gated_regbuf_chk #(
  parameter int WIDE_W     = 22,
  parameter int SPLIT_W    = 11,
  parameter int B_ODT_LANE = 9,
  parameter int B_CKE_LANE = 10,
  parameter int B_EXTRA0   = 11
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mode_split,
  input logic               map_b,
  input logic [WIDE_W-1:0]  din,
  input logic               odt_in,
  input logic               dcs_n,
  input logic               csr_n,
  input logic [WIDE_W-1:0]  qa,
  input logic [SPLIT_W-1:0] qb,
  input logic               odt_qa,
  input logic               odt_qb,
  input logic               cke_qa,
  input logic               cke_qb,
  input logic               cs_qa_n,
  input logic               cs_qb_n
);
  AST_WIDE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_split && !(dcs_n && csr_n)) |=> (qa == $past(din) && odt_qa == $past(odt_in))); // R1

  AST_SPLIT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    mode_split |=> (qb == qa[SPLIT_W-1:0] && odt_qb == odt_qa && cke_qb == cke_qa && cs_qb_n == cs_qa_n)); // R2

  AST_MAP_B_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_split && map_b && !(dcs_n && csr_n)) |=> (qb[B_ODT_LANE] == $past(din[B_EXTRA0]) && odt_qa == $past(din[B_ODT_LANE]))); // R3

  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (dcs_n && csr_n && $stable(mode_split)) |=> ($stable(qa) && $stable(qb))); // R4

  AST_CS_EVERY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cs_qa_n == $past(dcs_n))); // R6

  AST_SPLIT_UPPER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    mode_split |=> (qa[WIDE_W-1:SPLIT_W] == '0)); // R9

  AST_WIDE_B_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_split |=> (qb == '0 && !odt_qb && !cke_qb && !cs_qb_n)); // R9

  always @(negedge clk) begin
    if (rst_n == 1'b0) begin
      AST_RESET_LOW: assert (qa == '0 && qb == '0 && !odt_qa && !odt_qb && !cke_qa && !cke_qb && !cs_qa_n && !cs_qb_n); // R7
    end
  end
endmodule

bind cs_gated_regbuf cs_gated_regbuf_chk #(
  .WIDE_W(WIDE_W), .SPLIT_W(SPLIT_W),
  .B_ODT_LANE(B_ODT_LANE), .B_CKE_LANE(B_CKE_LANE), .B_EXTRA0(B_EXTRA0)
) chk_i (
  .clk(clk), .rst_n(rst_n), .mode_split(mode_split), .map_b(map_b),
  .din(din), .odt_in(odt_in), .dcs_n(dcs_n), .csr_n(csr_n),
  .qa(qa), .qb(qb), .odt_qa(odt_qa), .odt_qb(odt_qb),
  .cke_qa(cke_qa), .cke_qb(cke_qb), .cs_qa_n(cs_qa_n), .cs_qb_n(cs_qb_n)
);

// File: tb/cs_gated_regbuf_tb_top.sv
`timescale 1ns/1ps
module cs_gated_regbuf_tb_top;
  localparam int WW = 22;
  localparam int SW = 11;
  localparam int OW = WW + SW + 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_split = 1'b0;
  logic          map_b = 1'b0;
  logic [WW-1:0] din = '0;
  logic          odt_in = 1'b0;
  logic          cke_in = 1'b0;
  logic          dcs_n = 1'b0;
  logic          csr_n = 1'b0;
  logic [WW-1:0] qa;
  logic [SW-1:0] qb;
  logic odt_qa, odt_qb, cke_qa, cke_qb, cs_qa_n, cs_qb_n;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [OW-1:0] exp_q[$];
  string         tag_q[$];

  // reference state
  logic [WW-1:0] m_data = '0;
  logic m_split = 1'b0, m_odt = 1'b0, m_cke = 1'b0, m_cs = 1'b0;

  always #5 clk = ~clk;

  cs_gated_regbuf dut_i (
    .clk(clk), .rst_n(rst_n), .mode_split(mode_split), .map_b(map_b),
    .din(din), .odt_in(odt_in), .cke_in(cke_in), .dcs_n(dcs_n), .csr_n(csr_n),
    .qa(qa), .qb(qb), .odt_qa(odt_qa), .odt_qb(odt_qb),
    .cke_qa(cke_qa), .cke_qb(cke_qb), .cs_qa_n(cs_qa_n), .cs_qb_n(cs_qb_n)
  );

  function automatic logic [OW-1:0] actual_bundle();
    return {qa, qb, odt_qa, odt_qb, cke_qa, cke_qb, cs_qa_n, cs_qb_n};
  endfunction

  function automatic logic [OW-1:0] model_bundle();
    logic [WW-1:0] ea;
    logic [SW-1:0] eb;
    ea = m_split ? {{(WW-SW){1'b0}}, m_data[SW-1:0]} : m_data;
    eb = m_split ? m_data[SW-1:0] : '0;
    return {ea, eb, m_odt, m_split & m_odt, m_cke, m_split & m_cke,
            m_cs, m_split & m_cs};
  endfunction

  task automatic check(input logic [OW-1:0] act, input logic [OW-1:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: applies one word, updates the reference, queues the expectation
  task automatic step(input logic [WW-1:0] d, input logic o, input logic c,
                      input logic ds, input logic cr, input logic sp,
                      input logic mb, input string tag);
    logic [SW-1:0] mv;
    @(negedge clk);
    din = d; odt_in = o; cke_in = c; dcs_n = ds; csr_n = cr;
    mode_split = sp; map_b = mb;
    for (int k = 0; k < SW; k++) mv[k] = d[k];
    if (sp && mb) begin
      mv[9]  = d[11];
      mv[10] = d[12];
      m_odt  = d[9];
      m_cke  = d[10];
    end else begin
      m_odt = o;
      m_cke = c;
    end
    m_cs = ds;
    if (!(ds && cr)) m_data = sp ? {{(WW-SW){1'b0}}, mv} : d;
    m_split = sp;
    @(posedge clk);
    #1;
    exp_q.push_back(model_bundle());
    tag_q.push_back(tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (exp_q.size() > 0) begin
        logic [OW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(actual_bundle(), e, t);
      end
    end
  end

  task automatic drain();
    repeat (2) @(posedge clk);
    #7;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    // R7: reset state while clock runs
    repeat (3) @(negedge clk);
    din = '1; odt_in = 1; cke_in = 1; dcs_n = 0;
    @(negedge clk); #1;
    check(actual_bundle(), '0, "R7 reset holds outputs low");
    din = '0; odt_in = 0; cke_in = 0;
    @(negedge clk);
    rst_n = 1'b1;

    // R8: quiet inputs after release
    for (int i = 0; i < 4; i++) step('0, 0, 0, 0, 0, 0, 0, "R8 quiet after reset");

    // R1 / R5 wide loads, each select alone
    step(22'h2A5C3F, 1, 0, 0, 1, 0, 0, "R1 R5 wide load dcs low");
    step(22'h15A3C0, 0, 1, 1, 0, 0, 0, "R1 R5 wide load csr low");
    step(22'h3FFFFF, 1, 1, 0, 0, 0, 0, "R1 wide all ones");
    // R4 / R6 hold with control updates
    step(22'h000001, 0, 0, 1, 1, 0, 0, "R4 R6 wide hold ctrl moves");
    step(22'h123456, 1, 0, 1, 1, 0, 0, "R4 R6 wide hold again");
    step(22'h0F0F0F, 0, 1, 0, 1, 0, 0, "R1 R9 wide B outputs low");

    // R2 / R9 split mapping A
    step(22'h3FF800, 1, 1, 0, 1, 1, 0, "R2 R9 split A upper lanes ignored");
    step(22'h0007FF, 0, 1, 1, 0, 1, 0, "R2 split A all data ones");
    step(22'h000555, 1, 0, 0, 0, 1, 0, "R2 split A alternate");
    step(22'h0002AA, 0, 0, 1, 1, 1, 0, "R4 R6 split A hold");

    // R3 mapping B: dedicated ODT/CKE pins have no effect
    step(22'h000600, 1, 1, 0, 1, 1, 1, "R3 map B ctrl from lanes 9 and 10");
    step(22'h001800, 0, 0, 0, 1, 1, 1, "R3 map B data 9 10 from lanes 11 12");
    step(22'h0001FF, 1, 1, 1, 0, 1, 1, "R3 map B low lanes");
    step(22'h3FE000, 1, 1, 0, 0, 1, 1, "R3 R9 map B high lanes ignored");

    // R10: load wide, then switch to split on a holding edge
    step(22'h2B6D5B, 1, 0, 0, 1, 0, 0, "R10 wide preload");
    step(22'h000000, 0, 0, 1, 1, 1, 0, "R10 switch to split while held");
    step(22'h000000, 0, 1, 1, 1, 0, 0, "R10 switch back to wide while held");
    drain();

    // R7: asynchronous clear between edges
    @(posedge clk);
    #3;
    rst_n = 1'b0;
    #1;
    check(actual_bundle(), '0, "R7 async clear mid cycle");
    m_data = '0; m_split = 0; m_odt = 0; m_cke = 0; m_cs = 0;
    @(negedge clk);
    din = '0; odt_in = 0; cke_in = 0; dcs_n = 0; csr_n = 0; mode_split = 0; map_b = 0;
    @(negedge clk);
    rst_n = 1'b1;
    step('0, 0, 0, 0, 0, 0, 0, "R8 quiet after second reset");
    step('0, 0, 0, 0, 0, 0, 0, "R8 quiet after second reset");
    drain();
    finish_run();
  end
endmodule